// File: doc/BRIEF.md
# Receive Blanking Wait Timer

After a transmit frame ends, the antenna and receive front end ring for a while, and a decoder that listens during that time mistakes the ringing for data. This block produces a decoder-reset signal. The signal holds the receive decoders in reset for a programmable guard window, and the window begins at the end-of-transmit-frame pulse. The window is an 8-bit step count. Each step is 128 carrier-enable cycles, which at a 13.56 MHz carrier is 9.44 µs. The usable settings of 1 to 255 therefore give windows from one step up to roughly 2.4 ms.

Software can write the step count directly through a small write port. A write to the protocol-select register loads the step count with the minimum response time of the selected protocol class instead. Power-up and a low enable both return the step count to 0x1F. A one-cycle done pulse marks the cycle in which a window runs out. A setting of zero means no blanking.

Top module: `rxb_guard_timer`

## Requirements
- R1: After reset, `wait_rd` reads 0x1F and both `dec_rst` and `window_done` are low.
- R2: While `en` is low, the wait register returns to 0x1F, any active window is dropped (`dec_rst` low on the next cycle), and register writes and `tx_eof` pulses have no effect.
- R3: A write with `wr_sel`=0 stores `wr_data` in the wait register, and `wait_rd` shows the new value one cycle later.
- R4: A write with `wr_sel`=1 loads the wait register with a preset chosen by `wr_data[1:0]`: code 0 gives 1, code 1 gives 7, code 2 gives 19, code 3 gives 31. `wr_data[7:2]` are ignored.
- R5: A `tx_eof` pulse with a nonzero setting raises `dec_rst` on the next cycle. `dec_rst` then stays high for exactly setting × PRESCALE carrier-enabled cycles, for every setting up to 255.
- R6: The window advances only on cycles with `carrier_en` high. While `carrier_en` is low an active window never ends.
- R7: A `tx_eof` pulse during an active window, including one in the window's final cycle, restarts the window with its full length.
- R8: A `tx_eof` pulse while the setting is 0 leaves `dec_rst` low on the next cycle and ends any window already running, with no done pulse.
- R9: The window length is captured at `tx_eof`. A write in the same cycle as the pulse, or during the window, changes only later windows.
- R10: `window_done` pulses high for one cycle, in the cycle where `dec_rst` falls at the natural end of a window. It stays low when a window is restarted, cancelled or disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low forces defaults |
| carrier_en | input | 1 | One carrier period per high cycle |
| tx_eof | input | 1 | One-cycle pulse at end of transmit frame |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: wait register, 1: protocol select |
| wr_data | input | WAIT_W | Write data |
| dec_rst | output | 1 | Holds receive decoders in reset |
| wait_rd | output | WAIT_W | Wait register readback |
| window_done | output | 1 | One-cycle pulse when a window expires |

## Verification
Two pairs of events can land in the same cycle. In the first, a frame-end pulse meets a register write. The bench drives the write and the pulse together and checks that the window runs for the old length while the readback already shows the new value. In the second, a frame-end pulse meets the final step of a running window. The bench times the pulse onto the cycle in which the window would expire, and expects the reset to stay high with no done pulse and a full new window after it. A behavioural model that counts carrier cycles judges every cycle of both cases.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    PROTO_FAST = 2'd0,
    PROTO_PROX = 2'd1,
    PROTO_RSVD = 2'd2,
    PROTO_VIC  = 2'd3
  } proto_e;

  // Minimum response time of each protocol class, in steps.
  function automatic logic [7:0] proto_preset(proto_e p);
    logic [7:0] v;
    case (p)
      PROTO_FAST: v = 8'd1;
      PROTO_PROX: v = 8'd7;
      PROTO_RSVD: v = 8'd19;
      default:    v = 8'd31;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rxb_wait_reg.sv
module rxb_wait_reg #(
  parameter int                WAIT_W       = 8,
  parameter logic [WAIT_W-1:0] DEFAULT_WAIT = WAIT_W'(8'h1F)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WAIT_W-1:0] wr_data,
  output logic [WAIT_W-1:0] wait_q
);
  import rxb_pkg::*;

  logic [WAIT_W-1:0] wait_d;

  always_comb begin
    wait_d = wait_q;
    if (!en) begin
      wait_d = DEFAULT_WAIT;
    end else if (wr_en) begin
      if (wr_sel) wait_d = WAIT_W'(proto_preset(proto_e'(wr_data[1:0])));
      else        wait_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= DEFAULT_WAIT;
    else        wait_q <= wait_d;
  end

endmodule

// File: rtl/rxb_prescaler.sv
module rxb_prescaler #(
  parameter int PRESCALE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic carrier_en,
  output logic step_tick
);
  localparam int                PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0]  LAST  = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;

  assign step_tick = run & ~clr & carrier_en & (pre_q == LAST);

  always_comb begin
    pre_d = pre_q;
    if (clr || !run)      pre_d = '0;
    else if (carrier_en)  pre_d = (pre_q == LAST) ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/rxb_window.sv
module rxb_window #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_eof,
  input  logic [WAIT_W-1:0] len,
  input  logic              step_tick,
  output logic              active_q,
  output logic              done_q
);
  logic [WAIT_W-1:0] steps_q, steps_d;
  logic [WAIT_W-1:0] len_q, len_d;
  logic              active_d, done_d;

  always_comb begin
    steps_d  = steps_q;
    len_d    = len_q;
    active_d = active_q;
    done_d   = 1'b0;
    if (!en) begin
      active_d = 1'b0;
      steps_d  = '0;
    end else if (tx_eof) begin
      steps_d = '0;
      if (len == '0) begin
        active_d = 1'b0;
      end else begin
        active_d = 1'b1;
        len_d    = len;
      end
    end else if (active_q && step_tick) begin
      if (steps_q + WAIT_W'(1) == len_q) begin
        active_d = 1'b0;
        done_d   = 1'b1;
        steps_d  = '0;
      end else begin
        steps_d = steps_q + WAIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q  <= '0;
      len_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      steps_q  <= steps_d;
      len_q    <= len_d;
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

endmodule

// File: rtl/rxb_guard_timer.sv
module rxb_guard_timer #(
  parameter int                WAIT_W       = 8,
  parameter int                PRESCALE     = 128,
  parameter logic [WAIT_W-1:0] DEFAULT_WAIT = WAIT_W'(8'h1F)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              carrier_en,
  input  logic              tx_eof,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WAIT_W-1:0] wr_data,
  output logic              dec_rst,
  output logic [WAIT_W-1:0] wait_rd,
  output logic              window_done
);
  logic [WAIT_W-1:0] wait_q;
  logic              active_q;
  logic              step_tick;

  rxb_wait_reg #(.WAIT_W(WAIT_W), .DEFAULT_WAIT(DEFAULT_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wait_q(wait_q)
  );

  rxb_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(tx_eof | ~en), .run(active_q),
    .carrier_en(carrier_en), .step_tick(step_tick)
  );

  rxb_window #(.WAIT_W(WAIT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_eof(tx_eof), .len(wait_q),
    .step_tick(step_tick), .active_q(active_q), .done_q(window_done)
  );

  assign dec_rst = active_q;
  assign wait_rd = wait_q;

endmodule

// File: rtl/rxb_guard_timer_chk.sv
module rxb_guard_timer_chk #(
  parameter int                WAIT_W       = 8,
  parameter logic [WAIT_W-1:0] DEFAULT_WAIT = WAIT_W'(8'h1F)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              carrier_en,
  input logic              tx_eof,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [WAIT_W-1:0] wr_data,
  input logic              dec_rst,
  input logic [WAIT_W-1:0] wait_rd,
  input logic              window_done
);

  a_r2_disable_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!dec_rst && wait_rd == DEFAULT_WAIT && !window_done));

  a_r3_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && !wr_sel) |=> (wait_rd == $past(wr_data)));

  a_r4_prox_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && wr_sel && wr_data[1:0] == 2'd1) |=> (wait_rd == WAIT_W'(7)));

  a_r4_vic_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && wr_sel && wr_data[1:0] == 2'd3) |=> (wait_rd == WAIT_W'(31)));

  a_r7_eof_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_eof && wait_rd != '0) |=> (dec_rst && !window_done));

  a_r8_zero_no_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_eof && wait_rd == '0) |=> (!dec_rst && !window_done));

  a_r6_hold_without_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dec_rst && !carrier_en && !tx_eof) |=> dec_rst);

  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |-> $fell(dec_rst));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |=> !window_done);

endmodule

bind rxb_guard_timer rxb_guard_timer_chk #(
  .WAIT_W(WAIT_W), .DEFAULT_WAIT(DEFAULT_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .carrier_en(carrier_en), .tx_eof(tx_eof),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .dec_rst(dec_rst),
  .wait_rd(wait_rd), .window_done(window_done)
);

// File: tb/rxb_guard_timer_tb.sv
`timescale 1ns/100ps
module rxb_guard_timer_tb;
  localparam int P = 128;

  logic clk = 1'b0;
  logic rst_n, en, carrier_en, tx_eof, wr_en, wr_sel;
  logic [7:0] wr_data;
  logic dec_rst, window_done;
  logic [7:0] wait_rd;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done_flag = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  rxb_guard_timer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .carrier_en(carrier_en), .tx_eof(tx_eof),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .dec_rst(dec_rst),
    .wait_rd(wait_rd), .window_done(window_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: remaining carrier cycles of the window.
  int m_wait, m_remain;
  bit m_active, m_done;

  function automatic int preset(input int code);
    case (code)
      0: return 1;
      1: return 7;
      2: return 19;
      default: return 31;
    endcase
  endfunction

  always @(posedge clk) begin
    int old_wait;
    if (!rst_n) begin
      m_wait = 31; m_active = 0; m_remain = 0; m_done = 0;
    end else if (!en) begin
      m_wait = 31; m_active = 0; m_done = 0;
    end else begin
      old_wait = m_wait;
      m_done = 0;
      if (tx_eof) begin
        if (old_wait == 0) m_active = 0;
        else begin m_active = 1; m_remain = old_wait * P; end
      end else if (m_active && carrier_en) begin
        m_remain--;
        if (m_remain == 0) begin m_active = 0; m_done = 1; end
      end
      if (wr_en) m_wait = wr_sel ? preset(int'(wr_data[1:0])) : int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(dec_rst == m_active, cur_req, "model dec_rst", int'(dec_rst), int'(m_active));
      check(int'(wait_rd) == m_wait, cur_req, "model wait_rd", int'(wait_rd), m_wait);
      check(window_done == m_done, cur_req, "model window_done", int'(window_done), int'(m_done));
    end
  end

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  task automatic do_wr(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_eof;
    tx_eof = 1'b1;
    @(negedge clk);
    tx_eof = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (dec_rst && n < 40000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; en = 1'b1; carrier_en = 1'b1; tx_eof = 1'b0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(wait_rd == 8'h1F, "R1", "reset wait_rd", int'(wait_rd), 31);
    check(!dec_rst && !window_done, "R1", "reset outputs", int'(dec_rst), 0);

    // R3 direct write
    cur_req = "R3";
    do_wr(1'b0, 8'd5);
    check(wait_rd == 8'd5, "R3", "direct write", int'(wait_rd), 5);

    // R5 basic window
    cur_req = "R5";
    do_eof();
    check(dec_rst, "R5", "rise after eof", int'(dec_rst), 1);
    measure(n);
    check(n == 5 * P, "R5", "window length", n, 5 * P);
    check(window_done, "R10", "done at fall", int'(window_done), 1);
    @(negedge clk);
    check(!window_done, "R10", "done single cycle", int'(window_done), 0);

    // R4 protocol presets, upper bits ignored
    cur_req = "R4";
    do_wr(1'b1, 8'h00); check(wait_rd == 8'd1,  "R4", "code 0", int'(wait_rd), 1);
    do_wr(1'b1, 8'h01); check(wait_rd == 8'd7,  "R4", "code 1", int'(wait_rd), 7);
    do_wr(1'b1, 8'hFE); check(wait_rd == 8'd19, "R4", "code 2 high bits", int'(wait_rd), 19);
    do_wr(1'b1, 8'h03); check(wait_rd == 8'd31, "R4", "code 3", int'(wait_rd), 31);

    // R6 carrier gating
    cur_req = "R6";
    do_wr(1'b0, 8'd1);
    do_eof();
    carrier_en = 1'b0;
    repeat (300) @(negedge clk);
    check(dec_rst && !window_done, "R6", "held without carrier", int'(dec_rst), 1);
    carrier_en = 1'b1;
    measure(n);
    check(n == P, "R6", "length after gating", n, P);

    // R7 restart mid-window
    cur_req = "R7";
    do_wr(1'b0, 8'd3);
    do_eof();
    repeat (200) @(negedge clk);
    do_eof();
    measure(n);
    check(n == 3 * P, "R7", "restart full length", n, 3 * P);

    // R7/R10 eof on the final cycle of a window
    do_wr(1'b0, 8'd1);
    do_eof();
    repeat (P - 1) @(negedge clk);
    do_eof();
    check(dec_rst && !window_done, "R10", "restart at expiry, no done", int'(window_done), 0);
    measure(n);
    check(n == P, "R7", "restart at expiry length", n, P);

    // R9 write in same cycle as eof
    cur_req = "R9";
    do_wr(1'b0, 8'd2);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd1; tx_eof = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tx_eof = 1'b0;
    check(wait_rd == 8'd1, "R9", "readback new value", int'(wait_rd), 1);
    measure(n);
    check(n == 2 * P, "R9", "old length used", n, 2 * P);
    do_eof();
    measure(n);
    check(n == P, "R9", "new length next frame", n, P);

    // R8 zero setting
    cur_req = "R8";
    do_wr(1'b0, 8'd3);
    do_eof();
    repeat (50) @(negedge clk);
    do_wr(1'b0, 8'd0);
    do_eof();
    check(!dec_rst && !window_done, "R8", "zero cancels", int'(dec_rst), 0);
    do_eof();
    check(!dec_rst, "R8", "zero no blanking", int'(dec_rst), 0);

    // R2 disable
    cur_req = "R2";
    do_wr(1'b0, 8'd5);
    do_eof();
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!dec_rst && wait_rd == 8'h1F, "R2", "disable defaults", int'(wait_rd), 31);
    do_wr(1'b0, 8'd9);
    do_eof();
    check(!dec_rst && wait_rd == 8'h1F, "R2", "ignored while disabled", int'(wait_rd), 31);
    en = 1'b1;
    @(negedge clk);
    check(!dec_rst && !window_done, "R2", "no done after disable", int'(window_done), 0);

    // R5 maximum setting
    cur_req = "R5";
    do_wr(1'b0, 8'd255);
    do_eof();
    measure(n);
    check(n == 255 * P, "R5", "max window", n, 255 * P);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule